// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the digital core of a serial memory that answers on a two-wire I2C bus. A host addresses it with a 7-bit device address, sends a 16-bit word address as two bytes, and then either streams data bytes into a 32-byte page buffer or reads bytes back one after another. The bus lines are oversampled by the system clock; SCL is never used as a clock. SDA is modelled as open drain: the block only ever pulls the line low through a single drive-low output.

Written data is not stored while it arrives. It collects in the page buffer and is committed to the memory array only after a STOP. The commit runs as a timed internal write interval of a parameterised number of clock cycles. During that interval the block leaves the bus entirely, so a host can poll for completion by repeating an address probe until it is acknowledged. A write-protect input sampled at the STOP cancels the commit. The array is a byte-wide inferred RAM indexed by the low bits of the word address.

Top module: `eepromTarget`

## Requirements
- R1: After reset the block releases SDA (sdaDriveLow is 0), is not in a write interval, and acknowledges its own address at once.
- R2: The block acknowledges a device byte only when its upper seven bits equal 1010 followed by the DEV_LOW parameter. Bit 0 of that byte selects a read (1) or a write (0). Any other device byte gets no acknowledge, and the block ignores the bus until the next START.
- R3: In a write, the first two bytes after the device byte set the word address, high byte first. Each further byte goes into the page buffer at the current address. Only the low 5 address bits then increment, wrapping from 31 to 0; the upper bits stay fixed.
- R4: Buffered bytes reach the memory only when a STOP ends the write. A START that comes before the STOP throws away everything buffered so far, and no write interval follows.
- R5: A STOP that commits buffered data starts a write interval of WRITE_CYCLES clock cycles. During that interval the block keeps SDA released, so its own address is not acknowledged. After the interval it acknowledges again.
- R6: When wpIn is 1 at the STOP, the memory is unchanged, the buffer is discarded, and no write interval follows.
- R7: A read returns the byte at the current address and then advances the full address by one, so reads can cross page boundaries. A random read is a write of the two address bytes, then a repeated START and a read. The host's ACK continues a sequential read. After the host's NACK, the block releases SDA.
- R8: A START or STOP that arrives before all eight bits of a data byte have been received drops that byte. Complete bytes buffered earlier in the same write are still committed at the STOP.
- R9: The block only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired level) |
| wpIn | input | 1 | Write protect, 1 blocks the commit |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two functions can act in the same cycle: STOP detection, which requests a commit, and the write-protect gate, which must cancel that commit. The bench provokes this by holding wpIn high across the STOP of a write. It then judges the result by probing the address straight away (an acknowledge means no write interval started) and by reading the target byte back. A second overlap is the write interval against a host that probes during it. This is provoked by polling right after a committing STOP, and the bench expects no acknowledge then and an acknowledge once the interval is over.

// File: rtl/eepromPkg.sv
package eepromPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       loadHi;     // rxByte is the upper word address byte
    logic       loadLo;     // rxByte is the lower word address byte
    logic       storeByte;  // rxByte goes to the page buffer
    logic       readNext;   // rdByte taken, advance the address
    logic       dropPage;   // START seen, forget buffered bytes
    logic       commitReq;  // STOP seen, commit if anything buffered
    logic [7:0] rxByte;
  } ctrlStrobe_t;

endpackage

// File: rtl/eepromSync.sv
module eepromSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  localparam int LINES = 2;

  logic [LINES-1:0] lineIn;
  logic [LINES-1:0] lineNow;
  logic [LINES-1:0] linePrev;

  assign lineIn = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], lineIn[g]};
    end
    assign lineNow[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '1;
    else       linePrev <= lineNow;
  end

  assign sclLvl  = lineNow[1];
  assign sdaLvl  = lineNow[0];
  assign sclRise = lineNow[1] & ~linePrev[1];
  assign sclFall = ~lineNow[1] & linePrev[1];
  assign startEv = lineNow[1] & linePrev[1] & linePrev[0] & ~lineNow[0];
  assign stopEv  = lineNow[1] & linePrev[1] & ~linePrev[0] & lineNow[0];

endmodule

// File: rtl/eepromCtrl.sv
module eepromCtrl
  import eepromPkg::*;
#(
  parameter logic [2:0] DEV_LOW = 3'b000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclLvl,
  input  logic        sdaLvl,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startEv,
  input  logic        stopEv,
  input  logic        busy,
  input  logic [7:0]  rdByte,
  output ctrlStrobe_t strobe,
  output logic        sdaDriveLow
);

  localparam logic [6:0] DEV_ID  = {4'b1010, DEV_LOW};
  localparam logic [3:0] BYTE_NB = 4'd8;

  busState_t  state;
  logic [3:0] bitCnt;
  logic       ackPhase;
  logic [7:0] shiftReg;
  logic [7:0] txShift;
  logic       hostAck;

  logic isRx, byteDone, ackEnd, devHit;

  assign isRx     = (state == ST_DEV) || (state == ST_AHI) ||
                    (state == ST_ALO) || (state == ST_WDATA);
  assign byteDone = isRx && sclFall && (bitCnt == BYTE_NB) && !ackPhase;
  assign ackEnd   = sclFall && ackPhase;
  assign devHit   = (shiftReg[7:1] == DEV_ID);

  // strobes towards the datapath
  always_comb begin
    strobe        = '0;
    strobe.rxByte = shiftReg;
    if (!busy) begin
      if (startEv) begin
        strobe.dropPage = 1'b1;
      end else if (stopEv) begin
        strobe.commitReq = 1'b1;
      end else begin
        if (byteDone) begin
          case (state)
            ST_AHI:   strobe.loadHi    = 1'b1;
            ST_ALO:   strobe.loadLo    = 1'b1;
            ST_WDATA: strobe.storeByte = 1'b1;
            default:  ;
          endcase
        end
        if (ackEnd && state == ST_DEV && shiftReg[0] && sdaDriveLow)
          strobe.readNext = 1'b1;
        if (ackEnd && state == ST_RDATA && !hostAck)
          strobe.readNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      ackPhase    <= 1'b0;
      shiftReg    <= '0;
      txShift     <= '0;
      hostAck     <= 1'b1;
      sdaDriveLow <= 1'b0;
    end else if (busy) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      ackPhase    <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (startEv) begin
      state       <= ST_DEV;
      bitCnt      <= '0;
      ackPhase    <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (stopEv) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      ackPhase    <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (isRx) begin
      if (sclRise && !ackPhase && bitCnt < BYTE_NB) begin
        shiftReg <= {shiftReg[6:0], sdaLvl};
        bitCnt   <= bitCnt + 4'd1;
      end
      if (byteDone) begin
        if (state == ST_DEV && !devHit) begin
          state  <= ST_IDLE;
          bitCnt <= '0;
        end else begin
          ackPhase    <= 1'b1;
          sdaDriveLow <= 1'b1;
        end
      end
      if (ackEnd) begin
        ackPhase    <= 1'b0;
        bitCnt      <= '0;
        sdaDriveLow <= 1'b0;
        case (state)
          ST_DEV: begin
            if (shiftReg[0]) begin
              state       <= ST_RDATA;
              txShift     <= rdByte;
              sdaDriveLow <= ~rdByte[7];
            end else begin
              state <= ST_AHI;
            end
          end
          ST_AHI:  state <= ST_ALO;
          ST_ALO:  state <= ST_WDATA;
          default: state <= ST_WDATA;
        endcase
      end
    end else if (state == ST_RDATA) begin
      if (sclRise) begin
        if (ackPhase)               hostAck <= sdaLvl;
        else if (bitCnt < BYTE_NB)  bitCnt  <= bitCnt + 4'd1;
      end
      if (sclFall) begin
        if (ackPhase) begin
          ackPhase <= 1'b0;
          bitCnt   <= '0;
          if (!hostAck) begin
            txShift     <= rdByte;
            sdaDriveLow <= ~rdByte[7];
          end else begin
            state       <= ST_IDLE;
            sdaDriveLow <= 1'b0;
          end
        end else if (bitCnt == BYTE_NB) begin
          sdaDriveLow <= 1'b0;
          ackPhase    <= 1'b1;
        end else begin
          txShift     <= {txShift[6:0], 1'b0};
          sdaDriveLow <= ~txShift[6];
        end
      end
    end
  end

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !sdaDriveLow); // R5

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclLvl); // R9

  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && byteDone && !devHit && !busy) |=> !sdaDriveLow); // R2

endmodule

// File: rtl/eepromData.sv
module eepromData
  import eepromPkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 1250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        wpIn,
  output logic [7:0]  rdByte,
  output logic        busy
);

  localparam int MAW = $clog2(MEM_BYTES);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int CW  = $clog2(WRITE_CYCLES + 1);
  localparam logic [PW:0]   PAGE_END = (PW+1)'(PAGE_BYTES);
  localparam logic [CW-1:0] BUSY_LEN = CW'(WRITE_CYCLES);

  logic [15:0]           addr;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [CW-1:0]         busyCnt;
  logic [PW:0]           commitIdx;
  logic [7:0]            mem [MEM_BYTES];

  logic            startCommit;
  logic            commitSlot;
  logic [MAW-1:0]  commitAddr;

  assign busy        = (busyCnt != '0);
  assign startCommit = strobe.commitReq && !wpIn && (|pageValid);
  assign commitSlot  = busy && (commitIdx < PAGE_END) &&
                       pageValid[commitIdx[PW-1:0]];
  assign commitAddr  = {addr[MAW-1:PW], commitIdx[PW-1:0]};
  assign rdByte      = mem[addr[MAW-1:0]];

  // word address: loaded by bytes, page-wrapped on writes, linear on reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (strobe.loadHi) begin
      addr[15:8] <= strobe.rxByte;
    end else if (strobe.loadLo) begin
      addr[7:0] <= strobe.rxByte;
    end else if (strobe.storeByte) begin
      addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
    end else if (strobe.readNext) begin
      addr <= addr + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte) pageBuf[addr[PW-1:0]] <= strobe.rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageValid <= '0;
    end else if (strobe.dropPage || (strobe.commitReq && wpIn)) begin
      pageValid <= '0;
    end else if (strobe.storeByte) begin
      pageValid[addr[PW-1:0]] <= 1'b1;
    end else if (busyCnt == CW'(1)) begin
      pageValid <= '0;
    end
  end

  // write interval timer and commit walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt   <= '0;
      commitIdx <= PAGE_END;
    end else if (startCommit) begin
      busyCnt   <= BUSY_LEN;
      commitIdx <= '0;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
      if (commitIdx < PAGE_END) commitIdx <= commitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commitSlot) mem[commitAddr] <= pageBuf[commitIdx[PW-1:0]];
  end

  AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |=> (addr[15:PW] == $past(addr[15:PW]))); // R3

  AST_WP_NO_INTERVAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitReq && wpIn && !busy) |=> !busy); // R6

  AST_STOP_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitReq && !wpIn && (|pageValid)) |=> busy); // R4

endmodule

// File: rtl/eepromTarget.sv
module eepromTarget
  import eepromPkg::*;
#(
  parameter logic [2:0] DEV_LOW      = 3'b000,
  parameter int         MEM_BYTES    = 1024,
  parameter int         PAGE_BYTES   = 32,
  parameter int         WRITE_CYCLES = 1250000,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaDriveLow
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic busy;
  logic [7:0] rdByte;
  ctrlStrobe_t strobe;

  eepromSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  eepromCtrl #(.DEV_LOW(DEV_LOW)) uCtrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .busy(busy), .rdByte(rdByte), .strobe(strobe), .sdaDriveLow(sdaDriveLow)
  );

  eepromData #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wpIn(wpIn),
    .rdByte(rdByte), .busy(busy)
  );

endmodule

// File: tb/eepromTarget_test.sv
`timescale 1ns/1ps
module eepromTarget_test;

  localparam int BUSY_CYC = 600;
  localparam int HALF     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostSda = 1'b1;
  logic wp = 1'b0;
  logic sdaDriveLow;
  logic sdaLine;

  int checks = 0;
  int errors = 0;
  int pullViolations = 0;
  bit done = 0;
  logic prevDrive = 1'b0;

  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];

  assign sdaLine = hostSda & ~sdaDriveLow;

  always #4 clk = ~clk;

  eepromTarget #(.DEV_LOW(3'b000), .MEM_BYTES(1024), .PAGE_BYTES(32),
                 .WRITE_CYCLES(BUSY_CYC)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .wpIn(wp),
    .sdaDriveLow(sdaDriveLow)
  );

  // R9 monitor: a new pull-down while the clock line is high
  always @(posedge clk) begin
    if (rstN && sdaDriveLow && !prevDrive && scl) pullViolations++;
    prevDrive <= sdaDriveLow;
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    hostSda = 1'b1; waitH();
    scl = 1'b1;     waitH();
    hostSda = 1'b0; waitH();
    scl = 1'b0;     repeat (2) @(negedge clk);
  endtask

  task automatic busStop();
    hostSda = 1'b0; waitH();
    scl = 1'b1;     waitH();
    hostSda = 1'b1; waitH();
  endtask

  task automatic writeBit(input logic b);
    hostSda = b; waitH();
    scl = 1'b1;  waitH();
    scl = 1'b0;  repeat (2) @(negedge clk);
  endtask

  task automatic readBit(output logic b);
    hostSda = 1'b1; waitH();
    scl = 1'b1; repeat (HALF/2) @(negedge clk);
    b = sdaLine; repeat (HALF/2) @(negedge clk);
    scl = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~giveAck);
  endtask

  task automatic poll(output logic acked);
    busStart();
    sendByte(8'hA0, acked);
    busStop();
  endtask

  task automatic writeAt(input logic [15:0] a, input int n);
    logic ak;
    busStart();
    sendByte(8'hA0, ak);
    sendByte(a[15:8], ak);
    sendByte(a[7:0], ak);
    for (int i = 0; i < n; i++) sendByte(wbuf[i], ak);
    busStop();
  endtask

  task automatic readAt(input logic [15:0] a, input int n);
    logic ak;
    busStart();
    sendByte(8'hA0, ak);
    sendByte(a[15:8], ak);
    sendByte(a[7:0], ak);
    busStart();
    sendByte(8'hA1, ak);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rbuf[i]);
    busStop();
  endtask

  task automatic waitInterval();
    repeat (BUSY_CYC + 100) @(negedge clk);
  endtask

  task automatic testReset();
    logic ak;
    checkEq("R1 sda released after reset", int'(sdaDriveLow), 0);
    poll(ak);
    checkEq("R1 address acked after reset", int'(ak), 1);
  endtask

  task automatic testAddress();
    logic ak;
    busStart();
    sendByte(8'hA2, ak);
    busStop();
    checkEq("R2 foreign address nacked", int'(ak), 0);
    busStart();
    sendByte(8'hA0, ak);
    busStop();
    checkEq("R2 own address acked", int'(ak), 1);
  endtask

  task automatic testPageWrap();
    logic ak;
    wbuf[0] = 8'h50; wbuf[1] = 8'h51; wbuf[2] = 8'h52;
    writeAt(16'h0040, 3);
    waitInterval();
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h11 + 8'(i);
    writeAt(16'h003C, 6);
    poll(ak);
    checkEq("R5 no ack during write interval", int'(ak), 0);
    waitInterval();
    poll(ak);
    checkEq("R5 ack after write interval", int'(ak), 1);
    readAt(16'h003C, 4);
    for (int i = 0; i < 4; i++) checkEq("R3 page bytes before wrap", int'(rbuf[i]), 8'h11 + i);
    readAt(16'h0020, 2);
    checkEq("R3 wrapped byte 0", int'(rbuf[0]), 8'h15);
    checkEq("R3 wrapped byte 1", int'(rbuf[1]), 8'h16);
  endtask

  task automatic testSeqRead();
    readAt(16'h003E, 4);
    checkEq("R7 seq read 0", int'(rbuf[0]), 8'h13);
    checkEq("R7 seq read 1", int'(rbuf[1]), 8'h14);
    checkEq("R7 seq read crosses page", int'(rbuf[2]), 8'h50);
    checkEq("R7 seq read 3", int'(rbuf[3]), 8'h51);
    checkEq("R7 sda released after nack", int'(sdaDriveLow), 0);
  endtask

  task automatic testRestartDiscard();
    logic ak;
    busStart();
    sendByte(8'hA0, ak);
    sendByte(8'h00, ak);
    sendByte(8'h41, ak);
    sendByte(8'h99, ak);
    busStart();
    busStop();
    poll(ak);
    checkEq("R4 no interval after discarded write", int'(ak), 1);
    readAt(16'h0041, 1);
    checkEq("R4 byte kept after restart", int'(rbuf[0]), 8'h51);
  endtask

  task automatic testProtect();
    logic ak;
    wp = 1'b1;
    wbuf[0] = 8'hEE;
    writeAt(16'h0042, 1);
    poll(ak);
    checkEq("R6 no interval under protect", int'(ak), 1);
    wp = 1'b0;
    readAt(16'h0042, 1);
    checkEq("R6 memory unchanged under protect", int'(rbuf[0]), 8'h52);
  endtask

  task automatic testPartial();
    logic ak;
    busStart();
    sendByte(8'hA0, ak);
    sendByte(8'h00, ak);
    sendByte(8'h40, ak);
    sendByte(8'h60, ak);
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1);
    busStop();
    waitInterval();
    readAt(16'h0040, 2);
    checkEq("R8 complete byte committed", int'(rbuf[0]), 8'h60);
    checkEq("R8 partial byte dropped", int'(rbuf[1]), 8'h51);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testAddress();
    testPageWrap();
    testSeqRead();
    testRestartDiscard();
    testProtect();
    testPartial();
    checkEq("R9 pull-down only while scl low", pullViolations, 0);
    finishRun();
  end

endmodule